// File: doc/BRIEF.md
# Processor Restart and Program Bank Sequencer

This block decides when a small embedded 8-bit processor begins work on a new data packet. It also decides which of two program banks the processor fetches its instructions from. Packet storage logic signals it each time a data bank is filled, and signals it each time a fresh program has been written into the idle program bank. The sequencer then picks the next filled data bank in round-robin order. It swaps program banks if a new program is waiting, and restarts the processor by raising its interrupt line for two clock cycles.

The processor reports the end of a job by writing to a dedicated output port. The sequencer then waits until no inbound data packet is being received. At that point it hands the finished bank to the transmit path with a one-cycle release pulse and frees that bank. A program that arrives while a job runs is remembered and only takes effect at the next restart, so traffic keeps flowing while the software changes between packets.

Top module: `restart_sequencer`

## Requirements
- R1: Every restart holds `cpu_irq_o` high for exactly two consecutive cycles, followed by at least one low cycle.
- R2: A restart happens only while at least one data bank holds a stored packet; with no bank filled, `cpu_irq_o` stays low.
- R3: When no new program has been signalled since the previous restart, `prog_bank_o` keeps its value across the restart.
- R4: When a new program is pending, `prog_bank_o` toggles in the first cycle that `cpu_irq_o` is high, and the pending flag is consumed so the following restart does not toggle again.
- R5: A `prog_loaded_i` pulse during a running job leaves `prog_bank_o` unchanged until the next restart, which then applies it.
- R6: A job ends only on a cycle with `wr_strobe_i` high and `port_id_i` equal to `DONE_PORT` (default 0xFF); strobes to any other port ID are ignored.
- R7: After a job ends, `release_o` pulses for one cycle with `release_bank_o` set to the served bank, and only in a cycle where `rx_busy_i` is low; while `rx_busy_i` is high the release waits.
- R8: At each restart `data_bank_o` becomes the first filled bank found searching upward, with wrap-around, from the bank after the one served last; empty banks are skipped.
- R9: A released bank counts as empty until it is filled again.
- R10: After reset, `cpu_irq_o` and `release_o` are low, `prog_bank_o` is 0, and `data_bank_o` is `NUM_DBANKS-1`, so that bank 0 is searched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbank_fill_i | input | NUM_DBANKS | One-cycle pulse per bank whose packet store just completed |
| prog_loaded_i | input | 1 | One-cycle pulse: a new program is complete in the idle program bank |
| rx_busy_i | input | 1 | An inbound data packet is being received |
| wr_strobe_i | input | 1 | Processor output write strobe |
| port_id_i | input | PORT_W | Processor output port ID |
| cpu_irq_o | output | 1 | Interrupt/restart line to the processor |
| prog_bank_o | output | 1 | Program bank the processor fetches from |
| data_bank_o | output | log2(NUM_DBANKS) | Data bank assigned to the current job |
| release_o | output | 1 | One-cycle pulse handing a finished bank to the transmit path |
| release_bank_o | output | log2(NUM_DBANKS) | Bank being released |

## Verification
The hardest case to reach is a program-loaded pulse that lands while a job is running, and whose bank swap must show only at the following restart. The bench fills two banks and loads a program between jobs. In the second job, after the interrupt pulse ends, it sends another program pulse, checks that the bank select holds over several cycles, and then confirms the swap at the next restart. Release gating is reached by asserting receive-busy before the completion write, so the finished job waits in its done state.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE1 = 3'd1,
    ST_PULSE2 = 3'd2,
    ST_RUN    = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_t;

  // True when a processor output write targets the completion port.
  function automatic logic is_done_write(input logic strobe,
                                         input logic [7:0] port,
                                         input logic [7:0] done_port);
    return strobe && (port == done_port);
  endfunction

endpackage

// File: rtl/dbank_tracker.sv
module dbank_tracker #(
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] fill_i,
  input  logic          take_i,
  input  logic          release_i,
  input  logic [IW-1:0] rel_idx_i,
  output logic          any_o,
  output logic [IW-1:0] cur_o
);

  logic [NB-1:0] valid_q;
  logic [IW-1:0] cur_q;
  logic [IW:0]   pick;

  // Round-robin search: first set bit strictly after 'after', wrapping.
  function automatic logic [IW:0] rr_pick(input logic [NB-1:0] v,
                                          input logic [IW-1:0] after);
    logic [IW:0] r;
    r = '0;
    for (int k = 1; k <= NB; k++) begin
      int j;
      j = (int'(after) + k) % NB;
      if (v[j] && !r[IW]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  assign pick  = rr_pick(valid_q, cur_q);
  assign any_o = pick[IW];
  assign cur_o = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      cur_q   <= IW'(NB - 1);
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (fill_i[b]) valid_q[b] <= 1'b1;
        else if (release_i && (rel_idx_i == IW'(b))) valid_q[b] <= 1'b0;
      end
      if (take_i) cur_q <= pick[IW-1:0];
    end
  end

  assert_release_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> valid_q[rel_idx_i]);
  assert_pick_filled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> valid_q[cur_q]);

endmodule

// File: rtl/prog_bank_ctrl.sv
module prog_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_loaded_i,
  input  logic take_i,
  output logic bank_o
);

  logic pend_q;
  logic bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      pend_q <= prog_loaded_i | (pend_q & ~take_i);
      if (take_i && pend_q) bank_q <= ~bank_q;
    end
  end

  assign bank_o = bank_q;

  assert_swap_at_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(take_i));

endmodule

// File: rtl/restart_fsm.sv
module restart_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_valid_i,
  input  logic done_wr_i,
  input  logic rx_busy_i,
  output logic take_o,
  output logic irq_o,
  output logic release_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (any_valid_i) state_d = ST_PULSE1;
      ST_PULSE1: state_d = ST_PULSE2;
      ST_PULSE2: state_d = ST_RUN;
      ST_RUN:    if (done_wr_i) state_d = ST_DONE;
      ST_DONE:   if (!rx_busy_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign take_o    = (state_q == ST_IDLE) && any_valid_i;
  assign irq_o     = (state_q == ST_PULSE1) || (state_q == ST_PULSE2);
  assign release_o = (state_q == ST_DONE) && !rx_busy_i;

  assert_irq_two_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |=> irq_o ##1 !irq_o);
  assert_start_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_valid_i));
  assert_release_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> !rx_busy_i);

endmodule

// File: rtl/restart_sequencer.sv
module restart_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_DBANKS = 4,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] DONE_PORT = 8'hFF,
  localparam int IW = (NUM_DBANKS > 1) ? $clog2(NUM_DBANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DBANKS-1:0] dbank_fill_i,
  input  logic                  prog_loaded_i,
  input  logic                  rx_busy_i,
  input  logic                  wr_strobe_i,
  input  logic [PORT_W-1:0]     port_id_i,
  output logic                  cpu_irq_o,
  output logic                  prog_bank_o,
  output logic [IW-1:0]         data_bank_o,
  output logic                  release_o,
  output logic [IW-1:0]         release_bank_o
);

  logic any_valid;
  logic take;
  logic done_wr;
  logic rel;
  logic [IW-1:0] cur_bank;

  assign done_wr = is_done_write(wr_strobe_i, 8'(port_id_i), 8'(DONE_PORT));

  dbank_tracker #(.NB(NUM_DBANKS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_i    (dbank_fill_i),
    .take_i    (take),
    .release_i (rel),
    .rel_idx_i (cur_bank),
    .any_o     (any_valid),
    .cur_o     (cur_bank)
  );

  prog_bank_ctrl u_prog (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_loaded_i (prog_loaded_i),
    .take_i        (take),
    .bank_o        (prog_bank_o)
  );

  restart_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_valid_i (any_valid),
    .done_wr_i   (done_wr),
    .rx_busy_i   (rx_busy_i),
    .take_o      (take),
    .irq_o       (cpu_irq_o),
    .release_o   (rel)
  );

  assign data_bank_o    = cur_bank;
  assign release_o      = rel;
  assign release_bank_o = cur_bank;

  assert_bank_only_at_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_bank_o) |-> $rose(cpu_irq_o));
  assert_bank_held_in_job_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_o && !$rose(cpu_irq_o)) |-> $stable(data_bank_o));

endmodule

// File: tb/restart_sequencer_test.sv
module restart_sequencer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fill = '0;
  logic       prog_ld = 1'b0;
  logic       rx_busy = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] port = '0;
  logic       irq, pbank, rel;
  logic [1:0] dbank, rbank;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int rel_q[$];
  bit monitor_on = 1'b0;

  always #10 clk = ~clk;

  restart_sequencer uut (
    .clk(clk), .rst_n(rst_n), .dbank_fill_i(fill), .prog_loaded_i(prog_ld),
    .rx_busy_i(rx_busy), .wr_strobe_i(wr), .port_id_i(port),
    .cpu_irq_o(irq), .prog_bank_o(pbank), .data_bank_o(dbank),
    .release_o(rel), .release_bank_o(rbank)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: restarts and releases compared against scoreboard queues.
  int irq_run = 0;
  always @(negedge clk) begin
    if (monitor_on) begin
      if (irq) begin
        irq_run++;
        if (irq_run == 1) begin
          if (exp_q.size() == 0) check(0, "R2 unexpected restart", 1, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            check(int'(dbank) == e / 2, "R8 restart bank", dbank, e / 2);
            check(int'(pbank) == e % 2, "R3/R4 program bank", pbank, e % 2);
          end
        end
        if (irq_run > 2) check(0, "R1 irq longer than two", irq_run, 2);
      end else begin
        if (irq_run != 0) check(irq_run == 2, "R1 irq width", irq_run, 2);
        irq_run = 0;
      end
      if (rel) begin
        if (rel_q.size() == 0) check(0, "R6/R7 unexpected release", 1, 0);
        else begin
          int b;
          b = rel_q.pop_front();
          check(int'(rbank) == b, "R7 release bank", rbank, b);
          check(!rx_busy, "R7 release while busy", rx_busy, 0);
        end
      end
    end
  end

  task automatic drive_fill(input logic [3:0] m);
    @(posedge clk); #2 fill = m;
    @(posedge clk); #2 fill = '0;
  endtask

  task automatic drive_prog();
    @(posedge clk); #2 prog_ld = 1'b1;
    @(posedge clk); #2 prog_ld = 1'b0;
  endtask

  task automatic drive_write(input logic [7:0] p);
    @(posedge clk); #2 wr = 1'b1; port = p;
    @(posedge clk); #2 wr = 1'b0; port = '0;
  endtask

  task automatic wait_job_running();
    do @(negedge clk); while (!irq);
    do @(negedge clk); while (irq);
  endtask

  task automatic finish_job(input int bank);
    rel_q.push_back(bank);
    drive_write(8'hFF);
    repeat (3) @(negedge clk);
    check(rel_q.size() == 0, "R7 release seen", rel_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(irq == 0, "R10 irq", irq, 0);
    check(rel == 0, "R10 release", rel, 0);
    check(pbank == 0, "R10 prog bank", pbank, 0);
    check(dbank == 3, "R10 data bank", dbank, 3);
    monitor_on = 1'b1;

    // R2: nothing filled, no restart
    repeat (6) @(negedge clk);
    check(irq == 0, "R2 idle without data", irq, 0);

    // First job: bank 0, program 0
    exp_q.push_back(0 * 2 + 0);
    drive_fill(4'b0001);
    wait_job_running();
    // R6: wrong port ignored
    drive_write(8'h10);
    repeat (3) @(negedge clk);
    check(rel == 0, "R6 other port ignored", rel, 0);
    // R7: completion while receiving waits
    #2 rx_busy = 1'b1;
    drive_write(8'hFF);
    repeat (4) @(negedge clk);
    check(rel == 0, "R7 held while busy", rel, 0);
    rel_q.push_back(0);
    @(posedge clk); #2 rx_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(rel_q.size() == 0, "R7 release after busy", rel_q.size(), 0);

    // R4/R8: program pending, banks 2 and 3 filled -> bank 2, program 1
    drive_prog();
    exp_q.push_back(2 * 2 + 1);
    exp_q.push_back(3 * 2 + 1);   // R3: no new program, stays 1
    drive_fill(4'b1100);
    wait_job_running();
    finish_job(2);
    wait_job_running();
    // R5: new program during job must not switch now
    drive_prog();
    repeat (4) begin
      @(negedge clk);
      check(pbank == 1, "R5 bank held during job", pbank, 1);
    end
    finish_job(3);

    // R9: bank 0 freed earlier; fill bank 1 -> wraps past empty 0, program swaps to 0
    repeat (4) @(negedge clk);
    check(irq == 0, "R9 freed banks idle", irq, 0);
    exp_q.push_back(1 * 2 + 0);
    drive_fill(4'b0010);
    wait_job_running();
    finish_job(1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all restarts seen", exp_q.size(), 0);
    check(irq == 0, "R2 idle at end", irq, 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

endmodule